// File: doc/BRIEF.md
# Bus Master Response Sequencer

This block is the master end of a system bus whose transfers have a separate address phase and data phase. A core hands it one request at a time. Each request carries an address, a read/write flag, a sequential/non-sequential flag and an opcode-fetch flag. The block shows the address and transfer type for one address clock. It then runs the data phase until the selected slave stops asking for more time.

Three slave responses steer the data phase. Wait adds one data clock for every clock it is sampled high. During a plain wait clock the address bus is parked at zero. Wait together with address hold keeps the transfer address, burst-read status and peripheral select on the bus without change. Last makes the next transfer the master issues non-sequential, so that an external decoder gets a clock in which to reselect a slave. The request flag is overridden only for that one transfer. The burst-read status and the active-low peripheral select are decoded once, when the request is accepted. They follow the address bus clock for clock.

The sequencer has five states. IDLE waits for a request. ADDR is the single address clock. DATA is the first data clock. WAIT is a data clock stretched by wait alone. AHOLD is a data clock stretched by wait with address hold. IDLE goes to ADDR on an accepted request, and ADDR always goes to DATA. From DATA, WAIT or AHOLD the next state is AHOLD if wait and hold are both high, and WAIT if wait alone is high. With wait low, the transfer completes: the next state is ADDR if a new request is accepted at that edge, and IDLE otherwise.

Top module: `bms_master`

## Requirements
- R1: After reset the block is in IDLE. bus_aphase and bus_dphase are low, bus_addr is zero, bus_periph_n is high and req_ready is high.
- R2: A request accepted (req_valid and req_ready high) at an edge gives exactly one clock with bus_aphase high, followed by a clock with bus_dphase high. In both clocks bus_addr and bus_write show the request.
- R3: Each edge at which slv_wait is high in a data clock adds one more data clock (bus_dphase high, bus_aphase low). While slv_wait is high in a data clock, req_ready is low. A data clock entered through wait alone shows bus_addr zero, bus_periph_n high and bus_burst_rd low.
- R4: When slv_wait and slv_ahold are both high at an edge in DATA or AHOLD, the next clock is an address-hold clock. In it, bus_addr, bus_periph_n and bus_burst_rd are unchanged and equal the transfer's values.
- R5: slv_ahold high with slv_wait low has no effect: the data phase completes and req_ready is high in that clock.
- R6: In a data clock with slv_wait low, req_ready is high. A request accepted there starts its address clock on the next clock. With no request, the block returns to IDLE.
- R7: If slv_last is high at any edge of a data phase (first, wait or hold clock), the next transfer issued shows bus_seq low even when req_seq is high. This holds even if IDLE clocks come in between. Only that one transfer is affected.
- R8: Apart from R7, bus_seq during the address and data clocks equals the req_seq of the request.
- R9: bus_burst_rd is high only when the request was an opcode fetch (req_fetch=1), a read (req_write=0) and its address has all bits at and above position ROM_BITS equal to zero. It follows the same clocks as the address bus.
- R10: bus_periph_n is low for an address whose top PIO_TOP_BITS bits are all ones.
- R11: bus_periph_n is also low when (address - win_base), taken unsigned, is less than win_size. A win_size of zero disables that window. The window inputs are sampled when the request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Core offers a transfer |
| req_ready | output | 1 | Transfer accepted at this edge when valid |
| req_addr | input | AW | Transfer address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_seq | input | 1 | 1 = sequential (burst continuation) |
| req_fetch | input | 1 | 1 = opcode fetch |
| win_base | input | AW | Programmable peripheral window base |
| win_size | input | AW | Programmable peripheral window size in bytes |
| slv_wait | input | 1 | Slave wait response |
| slv_ahold | input | 1 | Slave address-hold response |
| slv_last | input | 1 | Slave last response, forces re-decode |
| bus_addr | output | AW | Bus address |
| bus_aphase | output | 1 | Address clock strobe |
| bus_dphase | output | 1 | Data clock strobe |
| bus_write | output | 1 | Transfer direction |
| bus_seq | output | 1 | Transfer is sequential |
| bus_burst_rd | output | 1 | Opcode fetch from external ROM |
| bus_periph_n | output | 1 | Active-low peripheral area select |

## Verification
The bench builds the block with AW=16, PIO_TOP_BITS=4 and ROM_BITS=14. With these values the fixed peripheral area is 0xF000 and up, and the ROM region ends at 0x3FFF. The bench can therefore place addresses on both sides of each decode edge, and of a small programmable window, using a handful of literal values. The bench scripts wait runs, hold runs, last responses in the final clock and in a wait clock, and back-to-back hand-overs. A scoreboard compares every address clock against the expected transfer.

// File: rtl/bms_pkg.sv
package bms_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ADDR  = 3'd1,
        ST_DATA  = 3'd2,
        ST_WAIT  = 3'd3,
        ST_AHOLD = 3'd4
    } bms_state_e;

endpackage

// File: rtl/bms_decode.sv
module bms_decode #(
    parameter int AW           = 32,
    parameter int PIO_TOP_BITS = 4,
    parameter int ROM_BITS     = 20
) (
    input  logic [AW-1:0] addr,
    input  logic          fetch,
    input  logic          write,
    input  logic [AW-1:0] win_base,
    input  logic [AW-1:0] win_size,
    output logic          periph_hit,
    output logic          burst_rd
);

    logic          fixed_hit;
    logic          rom_hit;
    logic          win_hit;
    logic [AW-1:0] win_off;

    // fixed peripheral area: top bits all ones
    generate
        if (PIO_TOP_BITS > 0 && PIO_TOP_BITS <= AW) begin : g_fixed
            assign fixed_hit = &addr[AW-1 -: PIO_TOP_BITS];
        end else begin : g_nofixed
            assign fixed_hit = 1'b0;
        end
    endgenerate

    // external ROM region: all bits from ROM_BITS upward are zero
    generate
        if (ROM_BITS < AW) begin : g_rom
            assign rom_hit = ~|addr[AW-1:ROM_BITS];
        end else begin : g_romall
            assign rom_hit = 1'b1;
        end
    endgenerate

    // programmable window: unsigned offset below size
    always_comb begin
        win_off = addr - win_base;
        win_hit = (win_off < win_size);
    end

    assign periph_hit = fixed_hit | win_hit;
    assign burst_rd   = fetch & ~write & rom_hit;

endmodule

// File: rtl/bms_last_track.sv
module bms_last_track (
    input  logic clk,
    input  logic rst_n,
    input  logic in_dphase,
    input  logic slv_last,
    input  logic launch,
    output logic force_nonseq
);

    logic pend_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (launch) begin
            pend_q <= 1'b0;
        end else if (in_dphase && slv_last) begin
            pend_q <= 1'b1;
        end
    end

    // a last response sampled at the launching edge is honoured at once
    assign force_nonseq = pend_q | (in_dphase & slv_last);

endmodule

// File: rtl/bms_fsm.sv
module bms_fsm
    import bms_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic       slv_wait,
    input  logic       slv_ahold,
    output bms_state_e state,
    output logic       in_dphase,
    output logic       launch,
    output logic       ready
);

    bms_state_e state_q;
    bms_state_e state_d;
    logic       done;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        in_dphase = (state_q == ST_DATA) || (state_q == ST_WAIT) ||
                    (state_q == ST_AHOLD);
        done      = in_dphase & ~slv_wait;
        ready     = (state_q == ST_IDLE) | done;
        launch    = req_valid & ready;
        state     = state_q;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (launch) state_d = ST_ADDR;
            end
            ST_ADDR: begin
                state_d = ST_DATA;
            end
            ST_DATA, ST_WAIT, ST_AHOLD: begin
                if (slv_wait) begin
                    state_d = slv_ahold ? ST_AHOLD : ST_WAIT;
                end else begin
                    state_d = launch ? ST_ADDR : ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

endmodule

// File: rtl/bms_master.sv
module bms_master
    import bms_pkg::*;
#(
    parameter int AW           = 32,
    parameter int PIO_TOP_BITS = 4,
    parameter int ROM_BITS     = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [AW-1:0] req_addr,
    input  logic          req_write,
    input  logic          req_seq,
    input  logic          req_fetch,
    input  logic [AW-1:0] win_base,
    input  logic [AW-1:0] win_size,
    input  logic          slv_wait,
    input  logic          slv_ahold,
    input  logic          slv_last,
    output logic [AW-1:0] bus_addr,
    output logic          bus_aphase,
    output logic          bus_dphase,
    output logic          bus_write,
    output logic          bus_seq,
    output logic          bus_burst_rd,
    output logic          bus_periph_n
);

    bms_state_e    state;
    logic          in_dphase;
    logic          launch;
    logic          force_nonseq;
    logic          periph_hit;
    logic          burst_hit;

    logic [AW-1:0] xa_q;
    logic          xw_q;
    logic          xs_q;
    logic          xb_q;
    logic          xp_q;

    bms_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .slv_wait  (slv_wait),
        .slv_ahold (slv_ahold),
        .state     (state),
        .in_dphase (in_dphase),
        .launch    (launch),
        .ready     (req_ready)
    );

    bms_last_track u_last (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_dphase    (in_dphase),
        .slv_last     (slv_last),
        .launch       (launch),
        .force_nonseq (force_nonseq)
    );

    bms_decode #(
        .AW           (AW),
        .PIO_TOP_BITS (PIO_TOP_BITS),
        .ROM_BITS     (ROM_BITS)
    ) u_dec (
        .addr       (req_addr),
        .fetch      (req_fetch),
        .write      (req_write),
        .win_base   (win_base),
        .win_size   (win_size),
        .periph_hit (periph_hit),
        .burst_rd   (burst_hit)
    );

    // transfer register: captured once per accepted request
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            xa_q <= '0;
            xw_q <= 1'b0;
            xs_q <= 1'b0;
            xb_q <= 1'b0;
            xp_q <= 1'b0;
        end else if (launch) begin
            xa_q <= req_addr;
            xw_q <= req_write;
            xs_q <= req_seq & ~force_nonseq;
            xb_q <= burst_hit;
            xp_q <= periph_hit;
        end
    end

    // output process: visibility of the transfer per state
    always_comb begin
        bus_addr     = '0;
        bus_aphase   = 1'b0;
        bus_dphase   = 1'b0;
        bus_write    = 1'b0;
        bus_seq      = 1'b0;
        bus_burst_rd = 1'b0;
        bus_periph_n = 1'b1;
        unique case (state)
            ST_IDLE: begin
            end
            ST_ADDR: begin
                bus_aphase   = 1'b1;
                bus_addr     = xa_q;
                bus_write    = xw_q;
                bus_seq      = xs_q;
                bus_burst_rd = xb_q;
                bus_periph_n = ~xp_q;
            end
            ST_DATA, ST_AHOLD: begin
                bus_dphase   = 1'b1;
                bus_addr     = xa_q;
                bus_write    = xw_q;
                bus_seq      = xs_q;
                bus_burst_rd = xb_q;
                bus_periph_n = ~xp_q;
            end
            ST_WAIT: begin
                bus_dphase   = 1'b1;
                bus_write    = xw_q;
                bus_seq      = xs_q;
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/bms_master_chk.sv
module bms_master_chk
    import bms_pkg::*;
#(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input bms_state_e    state,
    input logic          req_valid,
    input logic          req_ready,
    input logic          slv_wait,
    input logic          slv_ahold,
    input logic          slv_last,
    input logic [AW-1:0] bus_addr,
    input logic          bus_aphase,
    input logic          bus_dphase,
    input logic          bus_write,
    input logic          bus_seq,
    input logic          bus_burst_rd,
    input logic          bus_periph_n
);

    a_r2_addr_then_data: assert property (@(posedge clk) disable iff (!rst_n)
        bus_aphase |=> (bus_dphase && !bus_aphase));

    a_r3_wait_extends: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_dphase && slv_wait) |=> (bus_dphase && !bus_aphase));

    a_r3_no_accept_in_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_dphase && slv_wait) |-> !req_ready);

    a_r4_addr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_DATA || state == ST_AHOLD) && slv_wait && slv_ahold)
        |=> (state == ST_AHOLD && $stable(bus_addr) && $stable(bus_periph_n)
             && $stable(bus_burst_rd)));

    a_r5_ahold_alone_completes: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_dphase && !slv_wait) |-> req_ready);

    a_r7_last_forces_nonseq: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_dphase && slv_last && !slv_wait && req_valid) |=> (bus_aphase && !bus_seq));

    a_r9_burst_only_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        bus_burst_rd |-> !bus_write);

endmodule

bind bms_master bms_master_chk #(.AW(AW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .state        (state),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .slv_wait     (slv_wait),
    .slv_ahold    (slv_ahold),
    .slv_last     (slv_last),
    .bus_addr     (bus_addr),
    .bus_aphase   (bus_aphase),
    .bus_dphase   (bus_dphase),
    .bus_write    (bus_write),
    .bus_seq      (bus_seq),
    .bus_burst_rd (bus_burst_rd),
    .bus_periph_n (bus_periph_n)
);

// File: tb/tb_bms_master.sv
module tb_bms_master;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 16;

    typedef struct packed {
        logic [AW-1:0] addr;
        logic          write;
        logic          seq;
        logic          burst;
        logic          periph_n;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW-1:0] req_addr = '0;
    logic          req_write = 1'b0;
    logic          req_seq = 1'b0;
    logic          req_fetch = 1'b0;
    logic [AW-1:0] win_base = 16'h5000;
    logic [AW-1:0] win_size = 16'h0100;
    logic          slv_wait = 1'b0;
    logic          slv_ahold = 1'b0;
    logic          slv_last = 1'b0;
    logic [AW-1:0] bus_addr;
    logic          bus_aphase;
    logic          bus_dphase;
    logic          bus_write;
    logic          bus_seq;
    logic          bus_burst_rd;
    logic          bus_periph_n;

    int   checks = 0;
    int   errs = 0;
    bit   finished = 1'b0;
    bit   last_pend = 1'b0;
    exp_t sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    bms_master #(.AW(AW), .PIO_TOP_BITS(4), .ROM_BITS(14)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_write(req_write), .req_seq(req_seq),
        .req_fetch(req_fetch), .win_base(win_base), .win_size(win_size),
        .slv_wait(slv_wait), .slv_ahold(slv_ahold), .slv_last(slv_last),
        .bus_addr(bus_addr), .bus_aphase(bus_aphase), .bus_dphase(bus_dphase),
        .bus_write(bus_write), .bus_seq(bus_seq), .bus_burst_rd(bus_burst_rd),
        .bus_periph_n(bus_periph_n)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic exp_periph_n(input logic [AW-1:0] a);
        logic [AW-1:0] off;
        off = a - win_base;
        return !((a[15:12] == 4'hF) || (off < win_size));
    endfunction

    // scoreboard monitor: every address clock is compared with the queue head
    always @(negedge clk) begin
        if (rst_n && bus_aphase && !finished) begin
            exp_t e;
            if (sb_q.size() == 0) begin
                chk(1'b0, "R2", "unexpected address clock", int'(bus_addr), 0);
            end else begin
                e = sb_q.pop_front();
                chk(bus_addr == e.addr, "R2", "addr", int'(bus_addr), int'(e.addr));
                chk(bus_write == e.write, "R2", "write", int'(bus_write), int'(e.write));
                chk(bus_seq == e.seq, "R7 R8", "seq", int'(bus_seq), int'(e.seq));
                chk(bus_burst_rd == e.burst, "R9", "burst", int'(bus_burst_rd), int'(e.burst));
                chk(bus_periph_n == e.periph_n, "R10 R11", "periph_n",
                    int'(bus_periph_n), int'(e.periph_n));
            end
        end
    end

    // last_mode: 0 none, 1 final data clock, 2 first wait clock
    task automatic xfer(input logic [AW-1:0] a, input logic w, input logic s,
                        input logic f, input int nwait, input int ahold_from,
                        input int last_mode, input logic ahold_only);
        exp_t e;
        e.addr     = a;
        e.write    = w;
        e.seq      = s & !last_pend;
        e.burst    = f & !w & (a[15:14] == 2'b00);
        e.periph_n = exp_periph_n(a);
        sb_q.push_back(e);
        last_pend  = 1'b0;
        req_valid = 1'b1; req_addr = a; req_write = w; req_seq = s; req_fetch = f;
        #1;
        chk(req_ready == 1'b1, "R6", "ready at launch", int'(req_ready), 1);
        @(negedge clk);
        req_valid = 1'b0; slv_wait = 1'b0; slv_ahold = 1'b0; slv_last = 1'b0;
        #1;
        chk(bus_aphase == 1'b1, "R2", "address clock", int'(bus_aphase), 1);
        @(negedge clk);
        #1;
        chk(bus_dphase && !bus_aphase && bus_addr == a, "R2", "data clock addr",
            int'(bus_addr), int'(a));
        for (int i = 0; i < nwait; i++) begin
            slv_wait  = 1'b1;
            slv_ahold = (ahold_from >= 0) && (i >= ahold_from);
            slv_last  = (last_mode == 2) && (i == 0);
            if (slv_last) last_pend = 1'b1;
            #1;
            chk(req_ready == 1'b0, "R3", "ready during wait", int'(req_ready), 0);
            @(negedge clk);
            #1;
            if ((ahold_from >= 0) && (i >= ahold_from)) begin
                chk(bus_dphase && bus_addr == a && bus_periph_n == e.periph_n
                    && bus_burst_rd == e.burst, "R4", "held addr",
                    int'(bus_addr), int'(a));
            end else begin
                chk(bus_dphase && !bus_aphase && bus_addr == '0 && bus_periph_n,
                    "R3", "parked addr in wait", int'(bus_addr), 0);
            end
        end
        slv_wait  = 1'b0;
        slv_ahold = ahold_only;
        slv_last  = (last_mode == 1);
        if (slv_last) last_pend = 1'b1;
        #1;
        chk(req_ready == 1'b1, ahold_only ? "R5" : "R6", "ready at completion",
            int'(req_ready), 1);
    endtask

    task automatic go_idle();
        req_valid = 1'b0;
        @(negedge clk);
        slv_wait = 1'b0; slv_ahold = 1'b0; slv_last = 1'b0;
        #1;
        chk(!bus_aphase && !bus_dphase && req_ready, "R6", "back to idle",
            int'({bus_aphase, bus_dphase, req_ready}), 1);
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1'b1;
            $display("  Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk(!bus_aphase && !bus_dphase && bus_addr == '0 && bus_periph_n && req_ready,
            "R1", "reset state", int'(bus_addr), 0);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk(!bus_aphase && !bus_dphase && req_ready, "R1", "idle after reset",
            int'(req_ready), 1);
        // R9 fetch from ROM, R8 plain nonseq
        xfer(16'h1000, 1'b0, 1'b0, 1'b1, 0, -1, 0, 1'b0);
        // back-to-back seq burst with two wait clocks (R3, R8)
        xfer(16'h1004, 1'b0, 1'b1, 1'b1, 2, -1, 0, 1'b0);
        // write held by wait+hold for two clocks (R4)
        xfer(16'h8000, 1'b1, 1'b0, 1'b0, 2, 0, 0, 1'b0);
        // fixed peripheral area, hold alone ignored, last at completion (R10, R5, R7)
        xfer(16'hF010, 1'b0, 1'b0, 1'b0, 0, -1, 1, 1'b1);
        // seq request forced nonseq (R7); last inside a wait clock
        xfer(16'h2000, 1'b0, 1'b1, 1'b1, 1, -1, 2, 1'b0);
        go_idle();
        // forced again after idle gap; fetch outside ROM; inside window (R7 R9 R11)
        xfer(16'h5000, 1'b0, 1'b1, 1'b1, 0, -1, 0, 1'b0);
        // seq passes again: only one transfer forced (R7 R8); wait then hold
        xfer(16'h50FF, 1'b0, 1'b1, 1'b0, 3, 1, 0, 1'b0);
        // just outside window (R11), ROM top edge fetch (R9)
        xfer(16'h5100, 1'b0, 1'b0, 1'b0, 0, -1, 0, 1'b0);
        xfer(16'h3FFC, 1'b0, 1'b0, 1'b1, 0, -1, 0, 1'b0);
        go_idle();
        win_size = '0;
        // zero size disables window (R11)
        xfer(16'h5000, 1'b0, 1'b0, 1'b0, 0, -1, 0, 1'b0);
        go_idle();
        chk(sb_q.size() == 0, "R2", "scoreboard drained", sb_q.size(), 0);
        report();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            chk(1'b0, "R2", "watchdog expired", 0, 1);
            report();
        end
    end

endmodule